// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a memory-mapped watchdog for a system-on-chip. A fixed divide-by-32 prescaler feeds a terminal counter whose limit is 2^N prescaled ticks. N is a 5-bit postscaler field in the control register. Once software turns the enable bit on, it must write a 16-bit magic key into the upper half-word of the control word often enough to keep the count from reaching its limit. When the limit is reached, the block does three things. It emits a one-cycle reset request, it latches a sticky timeout flag in a separate status register, and it starts the count again from zero while it stays enabled.

Both registers have three addresses: a plain write address, an alias that clears bits and an alias that sets bits. Each alias acts only on the bits written as 1, so software can change single bits without a read-modify-write. The status register also records whether the timeout struck while the system signalled an idle or a sleep state. A 2-bit clock-select field is read-only and reports a value fixed by a parameter. A window flag is stored and read back but has no effect on timing.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control word reads 0x0000_0380: enable bit 15 = 0, window flag bit 0 = 0, postscaler bits 12:8 = 3 and clock-select bits 7:6 = 2. The status word reads 0 and rst_req is low.
- R2: While enable (control bit 15) is 0, the prescaler and the counter hold at zero and no reset request is produced. A key write made while the block is disabled has no effect.
- R3: A timeout occurs 32·2^N clock edges after the edge that enabled the block or restarted it. N is control bits 12:8. While the block stays enabled, timeouts repeat with the same period.
- R4: rst_req is high for exactly one cycle per timeout. It rises on the edge at which the timeout occurs.
- R5: A write to word 0 with byte lanes 3 and 2 both enabled and data bits 31:16 equal to 0x5743 restarts the prescaler and the counter from zero, provided the block is enabled. Any other value, a write with only one upper lane, or a write to an alias address does not restart the count.
- R6: A timeout sets sticky status bit 4. On the same edge, status bit 2 is set if idle_in is high and status bit 3 is set if sleep_in is high.
- R7: The word addresses are: control at 0, control-clear at 1, control-set at 2, status at 4, status-clear at 5 and status-set at 6. A plain write replaces the writable bits in the enabled lower byte lanes. The clear alias clears each writable bit written as 1, and the set alias sets each one. The upper half-word is never stored.
- R8: Clock-select bits 7:6 always read back the parameter value, whatever is written to them. The window flag (bit 0) is written and read back like a normal bit and has no effect on the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_word | input | 3 | Word address of the write |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| rd_word | input | 3 | Word address of the read |
| rd_data | output | 32 | Read data for rd_word, combinational |
| idle_in | input | 1 | System is in an idle state |
| sleep_in | input | 1 | System is in a sleep state |
| rst_req | output | 1 | One-cycle reset request on timeout |

## Verification
A register write takes effect on the clock edge that samples it. The bench records the index of that edge, then predicts each reset request 32·2^N edges later and compares the edge index of the request it sees against that prediction. A scoreboard queue holds the predicted pulse edges. The monitor samples rst_req at every falling edge and pops one entry per pulse, so a pulse that is early, late or unexpected is reported. Register contents are read combinationally at a falling edge after the write edge, so status and control values are checked one cycle after the event that changed them.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int ADDR_W   = 3;
    localparam int POST_W   = 5;
    localparam int CSEL_W   = 2;
    localparam int BIT_EN   = 15;
    localparam int BIT_WIN  = 0;
    localparam int POST_LSB = 8;
    localparam int CSEL_LSB = 6;
    localparam int BIT_TMO  = 4;
    localparam int BIT_SLP  = 3;
    localparam int BIT_IDL  = 2;

    localparam logic [15:0] RESTART_KEY = 16'h5743;
    localparam logic [15:0] CTRL_WMASK  = 16'h9F01;
    localparam logic [15:0] STAT_WMASK  = 16'h001C;

    typedef enum logic [1:0] {
        ACC_BASE = 2'd0,
        ACC_CLR  = 2'd1,
        ACC_SET  = 2'd2,
        ACC_NONE = 2'd3
    } acc_e;

    function automatic logic [15:0] apply_acc(input acc_e op, input logic [15:0] old,
                                              input logic [15:0] dat, input logic [15:0] msk);
        logic [15:0] r;
        case (op)
            ACC_BASE: r = (old & ~msk) | (dat & msk);
            ACC_CLR:  r = old & ~(dat & msk);
            ACC_SET:  r = old | (dat & msk);
            default:  r = old;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/kwdt_presc.sv
module kwdt_presc #(
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    output logic             tick,
    output logic [PRE_W-1:0] pre
);
    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        tick = en && !restart && (&pre_q);
        if (!en || restart) pre_d = '0;
        else                pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign pre = pre_q;
endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
    parameter int POST_W = 5,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              restart,
    input  logic              tick,
    input  logic [POST_W-1:0] post,
    output logic              fire,
    output logic              rst_req,
    output logic [CNT_W-1:0]  cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             req;
    } cnt_t;

    cnt_t s_d, s_q;
    logic last;

    always_comb begin
        last    = (s_q.cnt == ((CNT_W'(1) << post) - CNT_W'(1)));
        fire    = tick && last;
        s_d     = s_q;
        s_d.req = fire;
        if (!en || restart)  s_d.cnt = '0;
        else if (tick)       s_d.cnt = last ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rst_req = s_q.req;
    assign cnt     = s_q.cnt;
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter logic [POST_W-1:0] POST_RST = 5'd3,
    parameter logic [CSEL_W-1:0] CSEL_RST = 2'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_word,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    input  logic              fire,
    input  logic              idle_in,
    input  logic              sleep_in,
    output logic              en,
    output logic [POST_W-1:0] post,
    output logic              key_hit,
    output logic              stat_tmo
);
    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] stat;
    } regs_t;

    localparam logic [15:0] CTRL_RST = 16'(POST_RST) << POST_LSB;
    localparam logic [15:0] CSEL_IMG = 16'(CSEL_RST) << CSEL_LSB;

    regs_t r_d, r_q;
    acc_e  acc;
    logic  sel_stat;
    logic [15:0] lane;

    always_comb begin
        sel_stat = wr_word[ADDR_W-1];
        lane     = {{8{wr_be[1]}}, {8{wr_be[0]}}};
        acc      = ACC_NONE;
        if (wr_en) begin
            case (wr_word[1:0])
                2'd0:    acc = ACC_BASE;
                2'd1:    acc = ACC_CLR;
                2'd2:    acc = ACC_SET;
                default: acc = ACC_NONE;
            endcase
        end

        key_hit = (acc == ACC_BASE) && !sel_stat && (&wr_be[3:2]) &&
                  (wr_data[31:16] == RESTART_KEY) && r_q.ctrl[BIT_EN];

        r_d = r_q;
        if (!sel_stat) r_d.ctrl = apply_acc(acc, r_q.ctrl, wr_data[15:0], lane & CTRL_WMASK);
        else           r_d.stat = apply_acc(acc, r_q.stat, wr_data[15:0], lane & STAT_WMASK);

        if (fire) begin
            r_d.stat[BIT_TMO] = 1'b1;
            if (idle_in)  r_d.stat[BIT_IDL] = 1'b1;
            if (sleep_in) r_d.stat[BIT_SLP] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.ctrl <= CTRL_RST;
            r_q.stat <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        if (rd_word[1:0] == 2'd3)       rd_data = '0;
        else if (rd_word[ADDR_W-1])     rd_data = {16'h0, r_q.stat};
        else                            rd_data = {16'h0, r_q.ctrl | CSEL_IMG};
    end

    assign en       = r_q.ctrl[BIT_EN];
    assign post     = r_q.ctrl[POST_LSB +: POST_W];
    assign stat_tmo = r_q.stat[BIT_TMO];
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter logic [POST_W-1:0] POST_RST = 5'd3,
    parameter logic [CSEL_W-1:0] CSEL_RST = 2'd2,
    parameter int                PRE_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_word,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_word,
    output logic [31:0]       rd_data,
    input  logic              idle_in,
    input  logic              sleep_in,
    output logic              rst_req
);
    localparam int CNT_W = 1 << POST_W;

    logic              en, key_hit, tick, fire, stat_tmo;
    logic [POST_W-1:0] post;
    logic [PRE_W-1:0]  pre_val;
    logic [CNT_W-1:0]  cnt_val;

    kwdt_regs #(.POST_RST(POST_RST), .CSEL_RST(CSEL_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_be(wr_be),
        .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data), .fire(fire),
        .idle_in(idle_in), .sleep_in(sleep_in), .en(en), .post(post),
        .key_hit(key_hit), .stat_tmo(stat_tmo)
    );

    kwdt_presc #(.PRE_W(PRE_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(key_hit), .tick(tick), .pre(pre_val)
    );

    kwdt_count #(.POST_W(POST_W), .CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .en(en), .restart(key_hit), .tick(tick), .post(post),
        .fire(fire), .rst_req(rst_req), .cnt(cnt_val)
    );
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int          CNT_W = 32,
    parameter int          PRE_W = 5,
    parameter logic [1:0]  CSEL  = 2'd2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             key_hit,
    input logic             rst_req,
    input logic             stat_tmo,
    input logic [CNT_W-1:0] cnt,
    input logic [PRE_W-1:0] pre,
    input logic [2:0]       rd_word,
    input logic [31:0]      rd_data
);
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r6_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> stat_tmo);

    a_r2_no_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rst_req);

    a_r2_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (cnt == '0 && pre == '0));

    a_r5_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        key_hit |=> (cnt == '0 && pre == '0));

    a_r8_csel_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word == 3'd0) |-> (rd_data[7:6] == CSEL));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .CSEL(CSEL_RST)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .key_hit(key_hit), .rst_req(rst_req),
    .stat_tmo(stat_tmo), .cnt(cnt_val), .pre(pre_val), .rd_word(rd_word), .rd_data(rd_data)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_word = '0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        idle_in = 1'b0;
    logic        sleep_in = 1'b0;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 1'b0;
    logic prev_req = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    kwdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word), .wr_be(wr_be),
        .wr_data(wr_data), .rd_word(rd_word), .rd_data(rd_data), .idle_in(idle_in),
        .sleep_in(sleep_in), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops one predicted pulse edge per observed pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_req) check("R4 pulse width", {31'b0, rst_req}, 32'h0);
            if (rst_req) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R3 unexpected pulse actual=%0d expected=none", cyc);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check("R3 pulse edge", 32'(cyc), 32'(e));
                end
            end
            prev_req <= rst_req;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be,
                      output int w);
        @(negedge clk);
        wr_en = 1'b1; wr_word = a; wr_data = d; wr_be = be;
        @(posedge clk);
        @(negedge clk);
        w = cyc;
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        rd_word = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int w, k, x;
        wait_cyc(3);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk(3'd0, 32'h0000_0380, "R1 control reset");
        rd_chk(3'd4, 32'h0000_0000, "R1 status reset");
        check("R1 rst_req reset", {31'b0, rst_req}, 32'h0);

        // R8 clock-select read-only, window flag stored
        wr(3'd0, 32'h0000_00C1, 4'b0011, x);
        rd_chk(3'd0, 32'h0000_0081, "R8 csel read-only and window flag");
        // R7 upper lanes not stored, non-key value
        wr(3'd0, 32'h1234_0000, 4'b1100, x);
        rd_chk(3'd0, 32'h0000_0081, "R7 upper half not stored");

        // R2 disabled: no pulses, key ignored
        wait_cyc(100);
        wr(3'd0, 32'h5743_0000, 4'b1100, x);
        wait_cyc(100);
        check("R2 no pulse while disabled", 32'(exp_q.size()), 32'h0);

        // R3 N=0, repeating period of 32 edges
        wr(3'd0, 32'h0000_8000, 4'b0011, w);
        exp_q.push_back(w + 32);
        exp_q.push_back(w + 64);
        wait_cyc(76);
        wr(3'd1, 32'h0000_8000, 4'b0011, x);
        rd_chk(3'd0, 32'h0000_0080, "R7 control clear alias");
        rd_chk(3'd4, 32'h0000_0010, "R6 timeout sticky");
        wr(3'd5, 32'h0000_0010, 4'b0001, x);
        rd_chk(3'd4, 32'h0000_0000, "R7 status clear alias");
        check("R3 both pulses seen", 32'(exp_q.size()), 32'h0);
        wait_cyc(150);

        // R5 key restart, N=1 (64 edges)
        wr(3'd0, 32'h0000_8100, 4'b0011, w);
        wait_cyc(40);
        wr(3'd0, 32'h5743_0000, 4'b1100, k);
        exp_q.push_back(k + 64);
        wait_cyc(20);
        wr(3'd0, 32'h5744_0000, 4'b1100, x);
        wr(3'd2, 32'h5743_0000, 4'b1100, x);
        wr(3'd0, 32'h5743_0000, 4'b1000, x);
        wait_cyc(60);
        wr(3'd1, 32'h0000_8000, 4'b0011, x);
        check("R5 restarted pulse seen", 32'(exp_q.size()), 32'h0);

        // R6 idle-state timeout, enable through set alias
        wr(3'd4, 32'h0000_0000, 4'b0011, x);
        wr(3'd0, 32'h0000_0000, 4'b0011, x);
        idle_in = 1'b1;
        wr(3'd2, 32'h0000_8000, 4'b0010, w);
        exp_q.push_back(w + 32);
        wait_cyc(40);
        wr(3'd1, 32'h0000_8000, 4'b0011, x);
        idle_in = 1'b0;
        rd_chk(3'd4, 32'h0000_0014, "R6 idle flag with timeout");

        // R7 set alias and base write on status
        wr(3'd6, 32'h0000_0008, 4'b0001, x);
        rd_chk(3'd4, 32'h0000_001C, "R7 status set alias");
        wr(3'd4, 32'h0000_0000, 4'b0011, x);
        rd_chk(3'd4, 32'h0000_0000, "R7 status base write");

        // R6 sleep-state timeout
        sleep_in = 1'b1;
        wr(3'd2, 32'h0000_8000, 4'b0010, w);
        exp_q.push_back(w + 32);
        wait_cyc(40);
        wr(3'd1, 32'h0000_8000, 4'b0011, x);
        sleep_in = 1'b0;
        rd_chk(3'd4, 32'h0000_0018, "R6 sleep flag with timeout");
        wait_cyc(50);
        check("R2 all predicted pulses consumed", 32'(exp_q.size()), 32'h0);

        finish_run();
    end
endmodule